// File: doc/BRIEF.md
# Programmable Event Counter Bank

This block watches a set of event sources and counts their activity in four programmable counters, next to a free-running timestamp. Every cycle each event source presents how many times its event fired in that cycle, together with a tag: a one-hot line state for cache-type sources, and a flag that marks bus-type transactions started by this processor. A single input gives the current privilege mode, where 1 means kernel and 0 means user. Each counter has a 32-bit function word. The function word picks a source and decides how that source's per-cycle count turns into an increment. The counter can add the raw count, add one when a threshold is met or, with the threshold inverted, add one when the count stays at or below it. It can also add one only on a rising transition of its condition. Privilege filters and a single global enable bit, held in counter 0's function word, gate all counting.

Function words are written through a plain write port, and a write is checked before it is accepted. The read side returns a snapshot. A request is handed over on a valid/ready pair, and the snapshot comes out on a second valid/ready pair. The bank latches all four function words, all four counter values and the timestamp on the single clock edge that accepts the request. A request is accepted when `rd_valid` and `rd_ready` are both high. `rd_ready` is high whenever the output holds nothing, or holds a snapshot that is being taken in the same cycle. While `snap_valid` is high and `snap_ready` is low, the snapshot holds stable and no new request is accepted. Counting carries on during a stall, so a stall never loses events.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset every function word, every event counter and the timestamp are zero, and `snap_valid` and `wr_err` are low.
- R2: The 64-bit timestamp increments by one on every clock after reset, whatever the function words hold.
- R3: With threshold field [31:24] zero, invert bit 23 clear and edge bit 18 clear, a counter adds the selected source's qualified count each cycle. Counters are 40 bits wide and wrap.
- R4: With a nonzero threshold field and invert clear, a counter adds one in each cycle where the qualified count is at least the threshold.
- R5: With invert bit 23 set, a counter adds one in each cycle where the qualified count is no greater than the threshold field.
- R6: With edge bit 18 set, a counter adds one only in a cycle where its condition is true and was false the cycle before. The condition is "qualified count nonzero" in plain mode, or the threshold test in threshold modes, ANDed with the privilege filter. A write to that counter clears the remembered condition.
- R7: User bit 16 enables counting while `priv_kernel` is 0, and kernel bit 17 enables counting while it is 1. With neither bit set, the counter never advances.
- R8: Enable bit 22 of counter 0's function word gates all four counters. While it is clear, no counter changes.
- R9: For cache sources (2 and 3), the unit-mask bits [11:8] select line states, with M=bit 11, E=bit 10, S=bit 9 and I=bit 8. The tag uses the same order, M=3 down to I=0. A count is qualified only when the tag shares a bit with the mask.
- R10: For bus sources (4 and 5), a count is qualified only when the source's local flag is set, unless all-agent bit 13 is set. Other sources ignore the unit mask.
- R11: A write whose event select [7:0] is 8 or greater leaves the function word unchanged and raises `wr_err` for exactly the next cycle. A write with a valid select is taken at the clock edge and causes no error.
- R12: A snapshot carries the function words, the counter values and the timestamp as they stood before the accepting edge. It stays stable while `snap_valid` is high and `snap_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_count | input | NUM_SRC*CNT_W | Per-cycle event counts; source s occupies bits [s*CNT_W +: CNT_W] |
| evt_state | input | NUM_SRC*4 | Per-source line-state tag (M=3, E=2, S=1, I=0) |
| evt_local | input | NUM_SRC | Per-source flag: transaction started by this processor |
| priv_kernel | input | 1 | Current privilege: 1 kernel, 0 user |
| wr_en | input | 1 | Function-word write strobe |
| wr_idx | input | IDX_W | Counter index of the write |
| wr_data | input | 32 | Function word to write |
| wr_err | output | 1 | Pulses the cycle after a rejected write |
| rd_valid | input | 1 | Snapshot request |
| rd_ready | output | 1 | Request can be accepted this cycle |
| snap_valid | output | 1 | Snapshot present |
| snap_ready | input | 1 | Consumer takes the snapshot |
| snap_fn | output | NUM_CTR*32 | Captured function words, counter i at [i*32 +: 32] |
| snap_ctr | output | NUM_CTR*CTR_W | Captured counter values, counter i at [i*CTR_W +: CTR_W] |
| snap_ts | output | TS_W | Captured timestamp |

## Verification
The assertions rely on three things about the inputs. At most one write happens per cycle. `priv_kernel` and the event buses are sampled as steady values at the clock edge. The consumer keeps `snap_ready` meaningful at every edge. The stimulus drives every input only at the falling edge, and it issues at most one write per cycle. It keeps every event count within CNT_W bits, makes each line-state tag one-hot, and randomizes `snap_ready` so that stalls, back-to-back takes and requests made while the output is full all occur.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int FN_W = 32;

  // Function word layout, most significant byte first.
  typedef struct packed {
    logic [7:0] thresh;   // [31:24]
    logic       inv;      // 23
    logic       glb_en;   // 22
    logic [2:0] rsv;      // [21:19]
    logic       edg;      // 18
    logic       kern;     // 17
    logic       usr;      // 16
    logic [7:0] umask;    // [15:8]  M=11 E=10 S=9 I=8, all-agent=13
    logic [7:0] sel;      // [7:0]
  } fn_t;

  localparam int UM_ALL_AGENT = 5;
endpackage

// File: rtl/evt_qualify.sv
module evt_qualify
  import evt_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int CNT_W = 4,
  parameter logic [NUM_SRC-1:0] CACHE_MASK = 8'b0000_1100,
  parameter logic [NUM_SRC-1:0] BUS_MASK = 8'b0011_0000
) (
  input  fn_t                      fn,
  input  logic [NUM_SRC*CNT_W-1:0] evt_count,
  input  logic [NUM_SRC*4-1:0]     evt_state,
  input  logic [NUM_SRC-1:0]       evt_local,
  output logic [CNT_W-1:0]         qcnt,
  output logic                     thr_mode,
  output logic                     hit
);
  logic [CNT_W-1:0] raw;
  logic [3:0]       tag;
  logic             loc, is_cache, is_bus, pass;
  logic [7:0]       qx;

  always_comb begin
    raw = '0;
    tag = '0;
    loc = 1'b0;
    is_cache = 1'b0;
    is_bus = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (fn.sel == 8'(s)) begin
        raw = evt_count[s*CNT_W +: CNT_W];
        tag = evt_state[s*4 +: 4];
        loc = evt_local[s];
        is_cache = CACHE_MASK[s];
        is_bus = BUS_MASK[s];
      end
    end
  end

  always_comb begin
    if (is_cache)    pass = |(fn.umask[3:0] & tag);
    else if (is_bus) pass = fn.umask[UM_ALL_AGENT] | loc;
    else             pass = 1'b1;
    qcnt = pass ? raw : '0;
    qx = 8'(qcnt);
    thr_mode = (fn.thresh != 8'd0) || fn.inv;
    if (!thr_mode)   hit = (qcnt != '0);
    else if (fn.inv) hit = (qx <= fn.thresh);
    else             hit = (qx >= fn.thresh);
  end
endmodule

// File: rtl/evt_counter_slot.sv
module evt_counter_slot
  import evt_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int CNT_W = 4,
  parameter int CTR_W = 40,
  parameter logic [NUM_SRC-1:0] CACHE_MASK = 8'b0000_1100,
  parameter logic [NUM_SRC-1:0] BUS_MASK = 8'b0011_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_global,
  input  logic                     priv_kernel,
  input  logic [NUM_SRC*CNT_W-1:0] evt_count,
  input  logic [NUM_SRC*4-1:0]     evt_state,
  input  logic [NUM_SRC-1:0]       evt_local,
  input  logic                     wr_load,
  input  logic [FN_W-1:0]          wr_data,
  output logic [FN_W-1:0]          fn_out,
  output logic [CTR_W-1:0]         ctr_out
);
  fn_t              fn_r;
  logic [CTR_W-1:0] ctr_r;
  logic             prev_r;
  logic [CNT_W-1:0] qcnt;
  logic             thr_mode, hit, mode_ok;
  logic [CTR_W-1:0] step;

  evt_qualify #(
    .NUM_SRC(NUM_SRC), .CNT_W(CNT_W),
    .CACHE_MASK(CACHE_MASK), .BUS_MASK(BUS_MASK)
  ) u_qual (
    .fn(fn_r), .evt_count(evt_count), .evt_state(evt_state),
    .evt_local(evt_local), .qcnt(qcnt), .thr_mode(thr_mode), .hit(hit)
  );

  assign mode_ok = (fn_r.usr & ~priv_kernel) | (fn_r.kern & priv_kernel);

  always_comb begin
    if (!en_global || !mode_ok) step = '0;
    else if (fn_r.edg)          step = CTR_W'(hit && !prev_r);
    else if (thr_mode)          step = CTR_W'(hit);
    else                        step = CTR_W'(qcnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fn_r   <= '0;
      ctr_r  <= '0;
      prev_r <= 1'b0;
    end else begin
      ctr_r  <= ctr_r + step;
      prev_r <= wr_load ? 1'b0 : (mode_ok && hit);
      if (wr_load) fn_r <= fn_t'(wr_data);
    end
  end

  assign fn_out  = fn_r;
  assign ctr_out = ctr_r;

  a_r8_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_global |=> ctr_r == $past(ctr_r));
  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fn_r.usr && !fn_r.kern) |=> ctr_r == $past(ctr_r));
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_r.thresh != 8'd0 || fn_r.inv || fn_r.edg) |=> (ctr_r - $past(ctr_r)) <= CTR_W'(1));
  a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_r.edg && prev_r && !wr_load) |=> ctr_r == $past(ctr_r));
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import evt_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int NUM_SRC = 8,
  parameter int CNT_W = 4,
  parameter int CTR_W = 40,
  parameter int TS_W = 64,
  parameter logic [NUM_SRC-1:0] CACHE_MASK = 8'b0000_1100,
  parameter logic [NUM_SRC-1:0] BUS_MASK = 8'b0011_0000,
  localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC*CNT_W-1:0] evt_count,
  input  logic [NUM_SRC*4-1:0]     evt_state,
  input  logic [NUM_SRC-1:0]       evt_local,
  input  logic                     priv_kernel,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [FN_W-1:0]          wr_data,
  output logic                     wr_err,
  input  logic                     rd_valid,
  output logic                     rd_ready,
  output logic                     snap_valid,
  input  logic                     snap_ready,
  output logic [NUM_CTR*FN_W-1:0]  snap_fn,
  output logic [NUM_CTR*CTR_W-1:0] snap_ctr,
  output logic [TS_W-1:0]          snap_ts
);
  logic [NUM_CTR*FN_W-1:0]  fn_all;
  logic [NUM_CTR*CTR_W-1:0] ctr_all;
  logic [TS_W-1:0]          ts_r;
  logic                     sel_ok, en_global, take;

  assign sel_ok    = (wr_data[7:0] < 8'(NUM_SRC));
  assign en_global = fn_all[22];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
    evt_counter_slot #(
      .NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .CTR_W(CTR_W),
      .CACHE_MASK(CACHE_MASK), .BUS_MASK(BUS_MASK)
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .en_global(en_global),
      .priv_kernel(priv_kernel), .evt_count(evt_count),
      .evt_state(evt_state), .evt_local(evt_local),
      .wr_load(wr_en && sel_ok && (wr_idx == IDX_W'(i))),
      .wr_data(wr_data),
      .fn_out(fn_all[i*FN_W +: FN_W]),
      .ctr_out(ctr_all[i*CTR_W +: CTR_W])
    );
  end

  assign rd_ready = !snap_valid || snap_ready;
  assign take     = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_r       <= '0;
      wr_err     <= 1'b0;
      snap_valid <= 1'b0;
      snap_fn    <= '0;
      snap_ctr   <= '0;
      snap_ts    <= '0;
    end else begin
      ts_r   <= ts_r + TS_W'(1);
      wr_err <= wr_en && !sel_ok;
      if (take) begin
        snap_valid <= 1'b1;
        snap_fn    <= fn_all;
        snap_ctr   <= ctr_all;
        snap_ts    <= ts_r;
      end else if (snap_ready) begin
        snap_valid <= 1'b0;
      end
    end
  end

  a_r2_ts_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ts_r == $past(ts_r) + TS_W'(1));
  a_r11_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_ok) |=> (fn_all == $past(fn_all)) && wr_err);
  a_r12_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_valid && !snap_ready) |=> snap_valid && $stable(snap_ts)
      && $stable(snap_ctr) && $stable(snap_fn));
  a_r12_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_valid && !snap_ready) |-> !rd_ready);
endmodule

// File: tb/evt_counter_bank_test.sv
`timescale 1ns/1ps
module evt_counter_bank_test;
  localparam int NC = 4, NS = 8, CW = 4, TW = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS*CW-1:0] evt_count = '0;
  logic [NS*4-1:0]  evt_state = '0;
  logic [NS-1:0]    evt_local = '0;
  logic             priv_kernel = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_idx = '0;
  logic [31:0]      wr_data = '0;
  logic             wr_err, rd_ready, snap_valid;
  logic             rd_valid = 1'b0, snap_ready = 1'b0;
  logic [NC*32-1:0] snap_fn;
  logic [NC*TW-1:0] snap_ctr;
  logic [63:0]      snap_ts;

  evt_counter_bank uut (
    .clk(clk), .rst_n(rst_n), .evt_count(evt_count), .evt_state(evt_state),
    .evt_local(evt_local), .priv_kernel(priv_kernel), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .snap_valid(snap_valid), .snap_ready(snap_ready),
    .snap_fn(snap_fn), .snap_ctr(snap_ctr), .snap_ts(snap_ts)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string phase_tag = "";

  logic [31:0] m_fn [NC];
  logic [TW-1:0] m_ctr [NC];
  logic m_prev [NC];
  logic [63:0] m_ts;
  logic m_sv, m_fresh, m_err;
  logic [31:0] e_fn [NC];
  logic [TW-1:0] e_ctr [NC];
  logic [63:0] e_ts;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string req_of(logic [31:0] f, logic [31:0] f0);
    if (!f0[22]) return "R8";
    if (!f[16] && !f[17]) return "R7";
    if (f[18]) return "R6";
    if (f[23]) return "R5";
    if (f[31:24] != 0) return "R4";
    if (f[7:0] == 2 || f[7:0] == 3) return "R9";
    if (f[7:0] == 4 || f[7:0] == 5) return "R10";
    return "R3";
  endfunction

  function automatic logic [3:0] qual(logic [31:0] f);
    int s = f[7:0];
    logic [3:0] c = evt_count[s*CW +: CW];
    if (s == 2 || s == 3) return ((f[11:8] & evt_state[s*4 +: 4]) != 0) ? c : 4'd0;
    if (s == 4 || s == 5) return (f[13] || evt_local[s]) ? c : 4'd0;
    return c;
  endfunction

  task automatic model();
    logic acc = rd_valid && (!m_sv || snap_ready);
    logic en = m_fn[0][22];
    if (acc) begin
      for (int i = 0; i < NC; i++) begin e_fn[i] = m_fn[i]; e_ctr[i] = m_ctr[i]; end
      e_ts = m_ts; m_sv = 1; m_fresh = 1;
    end else begin
      m_fresh = 0;
      if (snap_ready) m_sv = 0;
    end
    for (int i = 0; i < NC; i++) begin
      logic [31:0] f = m_fn[i];
      logic [3:0] q = qual(f);
      logic thr = (f[31:24] != 0) || f[23];
      logic hit = !thr ? (q != 0) : (f[23] ? ({4'd0, q} <= f[31:24]) : ({4'd0, q} >= f[31:24]));
      logic mo = (f[16] && !priv_kernel) || (f[17] && priv_kernel);
      logic [TW-1:0] st = 0;
      if (en && mo) st = f[18] ? TW'(hit && !m_prev[i]) : (thr ? TW'(hit) : TW'(q));
      m_ctr[i] = m_ctr[i] + st;
      m_prev[i] = mo && hit;
    end
    m_ts = m_ts + 1;
    m_err = wr_en && (wr_data[7:0] >= 8);
    if (wr_en && wr_data[7:0] < 8) begin
      m_fn[wr_idx] = wr_data;
      m_prev[wr_idx] = 0;
    end
  endtask

  task automatic compare();
    chk("R11", 64'(wr_err), 64'(m_err));
    chk("R12", 64'(snap_valid), 64'(m_sv));
    if (m_fresh) begin
      chk(phase_tag == "" ? "R2" : phase_tag, snap_ts, e_ts);
      for (int i = 0; i < NC; i++) begin
        chk(phase_tag == "" ? req_of(e_fn[i], e_fn[0]) : phase_tag,
            64'(snap_ctr[i*TW +: TW]), 64'(e_ctr[i]));
        chk(phase_tag == "" ? "R11" : phase_tag, 64'(snap_fn[i*32 +: 32]), 64'(e_fn[i]));
      end
    end
  endtask

  task automatic cyc(int rd_pct = 30);
    for (int s = 0; s < NS; s++) begin
      evt_count[s*CW +: CW] = CW'($urandom % 16);
      evt_state[s*4 +: 4] = 4'b0001 << ($urandom % 4);
      evt_local[s] = $urandom % 2;
    end
    priv_kernel = $urandom % 2;
    rd_valid = ($urandom % 100) < rd_pct;
    snap_ready = ($urandom % 3) != 0;
    @(posedge clk); #1; model();
    @(negedge clk); compare();
    wr_en = 0;
  endtask

  task automatic wr(int idx, logic [31:0] d);
    wr_en = 1; wr_idx = 2'(idx); wr_data = d;
    cyc(0);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  // fields: thresh[31:24] inv23 en22 edge18 kern17 user16 umask[15:8] sel[7:0]
  function automatic logic [31:0] mk(int th, bit inv, bit en, bit edg, bit k, bit u, int um, int sel);
    return {8'(th), inv, en, 3'b000, edg, k, u, 8'(um), 8'(sel)};
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NC; i++) begin m_fn[i] = 0; m_ctr[i] = 0; m_prev[i] = 0; end
    m_ts = 0; m_sv = 0; m_fresh = 0; m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1", 64'(snap_valid), 0);
    chk("R1", 64'(wr_err), 0);
    chk("R1", 64'(rd_ready), 1);
    phase_tag = "R1";
    for (int k = 0; k < 6; k++) cyc(100);
    phase_tag = "";
    // plain, threshold, inverted cache, edge bus (local only)
    wr(0, mk(0, 0, 1, 0, 1, 1, 0, 0));
    wr(1, mk(5, 0, 1, 0, 1, 1, 0, 1));
    wr(2, mk(3, 1, 1, 0, 1, 1, 8'h08, 2));
    wr(3, mk(0, 0, 1, 1, 1, 1, 0, 4));
    run(300);
    wr(3, mk(9, 0, 1, 1, 1, 1, 0, 6));
    run(200);
    // privilege filters and bus qualification
    wr(0, mk(0, 0, 1, 0, 0, 1, 0, 0));
    wr(1, mk(0, 0, 1, 0, 1, 0, 0, 3 ));
    wr(2, mk(0, 0, 1, 0, 1, 1, 0, 4));
    wr(3, mk(0, 0, 1, 0, 1, 1, 8'h20, 5));
    run(300);
    // cache state selection, neither mode, rejected writes
    wr(1, mk(0, 0, 1, 0, 0, 0, 0, 1));
    wr(2, mk(0, 0, 1, 0, 1, 1, 8'h06, 3));
    wr(1, mk(0, 0, 1, 0, 1, 1, 0, 8));
    wr(2, mk(0, 0, 1, 0, 1, 1, 0, 8'hff));
    run(300);
    // global enable cleared in counter 0
    wr(0, mk(0, 0, 0, 0, 1, 1, 0, 0));
    run(200);
    wr(0, mk(2, 0, 1, 0, 1, 1, 0, 7));
    run(100);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      if ($urandom % 10 == 0)
        wr($urandom % 4, mk(($urandom % 3 == 0) ? 0 : $urandom % 12, $urandom % 4 == 0,
                            $urandom % 8 != 0, $urandom % 4 == 0, $urandom % 2,
                            $urandom % 2, $urandom % 256, $urandom % 10));
      else cyc();
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule